// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, once per cycle, whether a hart should take an interrupt and which one. It receives the pending and enable vectors, the delegation mask, the current privilege level, and the global machine and supervisor interrupt-enable bits. Each candidate interrupt is gated by its own rule. A delegated interrupt is judged against the supervisor level. A non-delegated interrupt is judged against the machine level.

Among the eligible interrupts, the one with the lowest bit index wins. There is no fixed priority table. The block reports three things: a take strobe, a cause word with the interrupt flag in its top bit, and the privilege level that will handle the trap. Redirecting the program counter and updating status registers are left to the trap entry logic that consumes these outputs.

All three outputs are registered. They reflect the inputs present at the previous rising clock edge. The register width `XLEN` is a parameter, 32 or 64.

Top module: `irq_sel_top`

## Requirements
- R1: A bit is a candidate only when it is set in both `pendVec` and `enVec`. A pending bit whose enable is clear is never taken.
- R2: Privilege levels on `curPriv` are encoded as U=0, S=1, H=2, M=3. A candidate whose `delegMask` bit is 0 is eligible when `curPriv` is not M. It is also eligible when `curPriv` is M and `mGlobalIe` is 1.
- R3: A candidate whose `delegMask` bit is 1 is eligible when `curPriv` is U. It is also eligible when `curPriv` is S and `sGlobalIe` is 1. In H or M it is never eligible.
- R4: The eligible set is the union of the eligible delegated candidates and the eligible non-delegated candidates. `takeIrq` is 1 exactly when this set is non-empty.
- R5: When several interrupts are eligible, the one with the lowest bit index is selected.
- R6: When an interrupt is taken, `causeOut` holds the selected index in its low bits, with bit XLEN-1 set and all other bits zero.
- R7: `targetPriv` is S (1) when the selected bit is set in `delegMask` and `curPriv` is U or S. Otherwise it is M (3).
- R8: When no interrupt is eligible, `takeIrq` is 0, `causeOut` is 0 and `targetPriv` is M (3).
- R9: The outputs update at the rising clock edge after the inputs are applied. While `rst_n` is low, the outputs are `takeIrq`=0, `causeOut`=0 and `targetPriv`=M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pendVec | input | XLEN | Pending interrupt bits |
| enVec | input | XLEN | Per-interrupt enable bits |
| delegMask | input | XLEN | Bits delegated to supervisor level |
| curPriv | input | 2 | Current privilege level (U=0, S=1, H=2, M=3) |
| mGlobalIe | input | 1 | Machine-level global interrupt enable |
| sGlobalIe | input | 1 | Supervisor-level global interrupt enable |
| takeIrq | output | 1 | An interrupt is taken |
| causeOut | output | XLEN | Cause word: interrupt flag in bit XLEN-1, index below |
| targetPriv | output | 2 | Privilege level that handles the interrupt |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench drives each input vector at a falling edge and compares all three outputs at the next falling edge, half a period after the capturing edge. A directed latency check samples the outputs just before the capturing edge and expects the previous vector's values, then samples again after the edge and expects the new ones. The sweep covers every privilege level and both enable bits. Its pending and delegation patterns land on bit positions 0, 3, 17 and 31, so the upper bits of the cause field are exercised.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } privLvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mGate;      // non-delegated interrupts may fire
    logic sGate;      // delegated interrupts may fire
    logic sTargetOk;  // current level allows trapping into S
  } selCtrl_t;

endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  privLvl_e curPriv,
  input  logic     mGlobalIe,
  input  logic     sGlobalIe,
  output selCtrl_t ctl
);

  logic belowM;
  logic belowS;
  logic inM;
  logic inS;

  always_comb begin
    belowM = (curPriv != PRIV_M);
    belowS = (curPriv == PRIV_U);
    inM    = (curPriv == PRIV_M);
    inS    = (curPriv == PRIV_S);
    ctl.mGate     = belowM | (inM & mGlobalIe);
    ctl.sGate     = belowS | (inS & sGlobalIe);
    ctl.sTargetOk = belowS | inS;
  end

  AST_S_GATE_CLOSED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (curPriv == PRIV_M || curPriv == PRIV_H) |-> !ctl.sGate); // R3
  AST_M_GATE_OPEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (curPriv != PRIV_M) |-> ctl.mGate); // R2

endmodule

// File: rtl/irq_sel_lsb_enc.sv
module irq_sel_lsb_enc #(
  parameter int W = 32,
  localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    vecIn,
  output logic            anyHit,
  output logic [W-1:0]    oneHot,
  output logic [IDXW-1:0] idxOut
);

  logic [W:0] lowerHit;
  assign lowerHit[0] = 1'b0;

  for (genvar gi = 0; gi < W; gi++) begin : g_chain
    assign oneHot[gi]     = vecIn[gi] & ~lowerHit[gi];
    assign lowerHit[gi+1] = lowerHit[gi] | vecIn[gi];
  end

  assign anyHit = lowerHit[W];

  always_comb begin
    idxOut = '0;
    for (int i = 0; i < W; i++) begin
      if (oneHot[i]) idxOut = idxOut | IDXW'(i);
    end
  end

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pendVec,
  input  logic [XLEN-1:0] enVec,
  input  logic [XLEN-1:0] delegMask,
  input  selCtrl_t        ctl,
  output logic            takeIrq,
  output logic [XLEN-1:0] causeOut,
  output privLvl_e        targetPriv
);

  logic [XLEN-1:0] candVec;
  logic [XLEN-1:0] eligVec;
  logic [XLEN-1:0] winHot;
  logic [IDXW-1:0] winIdx;
  logic            anyElig;
  logic [XLEN-1:0] causeNext;
  privLvl_e        targetNext;

  always_comb begin
    candVec = pendVec & enVec;
    eligVec = (candVec & ~delegMask & {XLEN{ctl.mGate}})
            | (candVec &  delegMask & {XLEN{ctl.sGate}});
  end

  irq_sel_lsb_enc #(.W(XLEN)) u_enc (
    .vecIn (eligVec),
    .anyHit(anyElig),
    .oneHot(winHot),
    .idxOut(winIdx)
  );

  always_comb begin
    causeNext = '0;
    targetNext = PRIV_M;
    if (anyElig) begin
      causeNext[XLEN-1]   = 1'b1;
      causeNext[IDXW-1:0] = winIdx;
      if (ctl.sTargetOk && |(winHot & delegMask)) targetNext = PRIV_S;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      takeIrq    <= 1'b0;
      causeOut   <= '0;
      targetPriv <= PRIV_M;
    end else begin
      takeIrq    <= anyElig;
      causeOut   <= causeNext;
      targetPriv <= targetNext;
    end
  end

  AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> causeOut[XLEN-1]); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !takeIrq |-> (causeOut == '0 && targetPriv == PRIV_M)); // R8
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> ((($past(eligVec) >> causeOut[IDXW-1:0]) & XLEN'(1)) != '0)); // R4
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    takeIrq |-> (($past(eligVec) & ((XLEN'(1) << causeOut[IDXW-1:0]) - XLEN'(1))) == '0)); // R5
  AST_S_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (targetPriv == PRIV_S) |-> takeIrq); // R7
  AST_ONEHOT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winHot)); // R5

endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pendVec,
  input  logic [XLEN-1:0] enVec,
  input  logic [XLEN-1:0] delegMask,
  input  logic [1:0]      curPriv,
  input  logic            mGlobalIe,
  input  logic            sGlobalIe,
  output logic            takeIrq,
  output logic [XLEN-1:0] causeOut,
  output logic [1:0]      targetPriv
);

  selCtrl_t ctl;
  privLvl_e privIn;
  privLvl_e targetInt;

  assign privIn     = privLvl_e'(curPriv);
  assign targetPriv = targetInt;

  irq_sel_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .curPriv  (privIn),
    .mGlobalIe(mGlobalIe),
    .sGlobalIe(sGlobalIe),
    .ctl      (ctl)
  );

  irq_sel_dp #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .delegMask (delegMask),
    .ctl       (ctl),
    .takeIrq   (takeIrq),
    .causeOut  (causeOut),
    .targetPriv(targetInt)
  );

endmodule

// File: tb/irq_sel_top_tb.sv
module irq_sel_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [XL-1:0] pendVec = '0, enVec = '0, delegMask = '0;
  logic [1:0]    curPriv = 2'd3;
  logic          mGlobalIe = 1'b0, sGlobalIe = 1'b0;
  logic          takeIrq;
  logic [XL-1:0] causeOut;
  logic [1:0]    targetPriv;

  int passCnt = 0, failCnt = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sel_top #(.XLEN(XL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .enVec(enVec),
    .delegMask(delegMask), .curPriv(curPriv), .mGlobalIe(mGlobalIe),
    .sGlobalIe(sGlobalIe), .takeIrq(takeIrq), .causeOut(causeOut),
    .targetPriv(targetPriv)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    if (got === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [XL-1:0] p, e, d, input logic [1:0] pr,
                       input logic mie, sie,
                       output logic t, output logic [XL-1:0] c, output logic [1:0] tg);
    int idx;
    idx = -1;
    for (int i = XL-1; i >= 0; i--) begin
      logic ok;
      if (d[i]) ok = (pr == 2'd0) || (pr == 2'd1 && sie);
      else      ok = (pr != 2'd3) || mie;
      if (p[i] && e[i] && ok) idx = i;
    end
    t  = (idx >= 0);
    c  = t ? ((XL'(1) << (XL-1)) + XL'(idx)) : '0;
    tg = (t && d[idx] && pr <= 2'd1) ? 2'd1 : 2'd3;
  endtask

  function automatic logic [XL-1:0] spread(input logic [3:0] n);
    logic [XL-1:0] v;
    v = '0;
    v[0] = n[0]; v[3] = n[1]; v[17] = n[2]; v[31] = n[3];
    return v;
  endfunction

  task automatic apply(input logic [XL-1:0] p, e, d, input logic [1:0] pr,
                       input logic mie, sie);
    pendVec = p; enVec = e; delegMask = d; curPriv = pr;
    mGlobalIe = mie; sGlobalIe = sie;
  endtask

  task automatic checkNow(input string tag);
    logic t; logic [XL-1:0] c; logic [1:0] tg;
    model(pendVec, enVec, delegMask, curPriv, mGlobalIe, sGlobalIe, t, c, tg);
    @(posedge clk); @(negedge clk);
    if (!t) begin
      chk({tag, " R8 take"}, 64'(takeIrq), 64'(t));
      chk({tag, " R8 cause"}, 64'(causeOut), 64'(c));
      chk({tag, " R8 target"}, 64'(targetPriv), 64'(tg));
    end else begin
      chk({tag, " R4 take"}, 64'(takeIrq), 64'(t));
      chk({tag, " R5 R6 cause"}, 64'(causeOut), 64'(c));
      chk({tag, " R7 target"}, 64'(targetPriv), 64'(tg));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    apply('1, '1, '0, 2'd0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset values while rst_n low
    chk("R9 reset take", 64'(takeIrq), 64'd0);
    chk("R9 reset cause", 64'(causeOut), 64'd0);
    chk("R9 reset target", 64'(targetPriv), 64'd3);
    rst_n = 1'b1;

    // R1 pending without enable
    apply('1, '0, '0, 2'd0, 1'b1, 1'b1);
    checkNow("R1 no enable");
    apply(32'h0000_0F00, 32'h0000_0800, '0, 2'd3, 1'b1, 1'b0);
    checkNow("R1 partial enable");
    // R2 M level with MIE off / on
    apply(32'h10, 32'h10, '0, 2'd3, 1'b0, 1'b1);
    checkNow("R2 M masked");
    apply(32'h10, 32'h10, '0, 2'd3, 1'b1, 1'b0);
    checkNow("R2 M enabled");
    apply(32'h10, 32'h10, '0, 2'd2, 1'b0, 1'b0);
    checkNow("R2 H level");
    // R3 delegated in H, S, U
    apply(32'h20, 32'h20, 32'h20, 2'd2, 1'b1, 1'b1);
    checkNow("R3 H level");
    apply(32'h20, 32'h20, 32'h20, 2'd1, 1'b1, 1'b0);
    checkNow("R3 S masked");
    apply(32'h20, 32'h20, 32'h20, 2'd0, 1'b0, 1'b0);
    checkNow("R3 U level");

    // R9 latency: output must hold until the next rising edge
    apply(32'h4, 32'h4, '0, 2'd0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    apply(32'h40, 32'h40, '0, 2'd0, 1'b0, 1'b0);
    #(CLK_PERIOD/2 - 1);
    chk("R9 before edge", 64'(causeOut), 64'h8000_0002);
    @(negedge clk);
    chk("R9 after edge", 64'(causeOut), 64'h8000_0006);

    // near-exhaustive sweep
    for (int pr = 0; pr < 4; pr++)
      for (int mi = 0; mi < 2; mi++)
        for (int si = 0; si < 2; si++)
          for (int es = 0; es < 2; es++)
            for (int d = 0; d < 16; d++)
              for (int p = 0; p < 16; p++) begin
                apply(spread(4'(p)), es ? spread(4'b1011) : '1, spread(4'(d)),
                      2'(pr), 1'(mi), 1'(si));
                checkNow("sweep");
              end

    finished = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule